// File: doc/BRIEF.md
# Settable BCD Time-of-Day Counter

This block keeps a 24-hour time of day as six BCD digits, two each for hours, minutes and seconds. It runs from a fast system clock, 50 MHz by default. A prescaler turns that clock into a one-cycle tick once per second. While the clock is running, each tick advances the seconds. A wrap of the seconds carries into the minutes, and a wrap of the minutes carries into the hours.

A small control machine lets a user set the time with three push-button levels: mode, up and down. The buttons arrive already debounced. Each mode press steps the edit selection from running to hours, then to minutes, then to seconds, and then back to running. While a field is selected, the time is frozen and the up and down buttons move only that field. A 2-bit output names the current selection so that a display can highlight the field being edited.

Top module: `tod_clock`

## Requirements
- R1: After reset the digits read 12:00:00 and `edit_sel` is 0 (running).
- R2: `edit_sel` encodes 0 = running, 1 = hours, 2 = minutes, 3 = seconds. Each mode press steps it 0→1→2→3→0, taking effect at the clock edge that samples the press.
- R3: Every digit is always valid BCD: hours 00 to 23, minutes and seconds 00 to 59.
- R4: While running, the seconds advance by exactly one every `TICK_DIV` clocks. The first advance comes at the `TICK_DIV`-th rising edge after reset is released.
- R5: While running, seconds 59→00 carries into minutes, minutes 59→00 carries into hours, and 23:59:59 rolls over to 00:00:00.
- R6: While a field is selected, the time does not advance and the prescaler is held cleared. After the return to running, the first advance comes `TICK_DIV` edges after the edge that applied the mode press.
- R7: An up press while editing increments only the selected field. It wraps from the maximum (23 or 59) to 00 without carrying into a neighbouring field.
- R8: A down press while editing decrements only the selected field. It wraps from 00 to the maximum without borrowing from a neighbouring field.
- R9: Buttons act on their rising edge only: a press held for many cycles gives exactly one action.
- R10: Up and down rising together in the same cycle leave the time unchanged.
- R11: Up and down presses while running leave the time and `edit_sel` unchanged.
- R12: Events in the same cycle as a mode press still take effect. An up or down press in that cycle applies to the field selected before the press. A second tick in that cycle (while running) advances the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_mode | input | 1 | Debounced mode button level |
| btn_up | input | 1 | Debounced up button level |
| btn_down | input | 1 | Debounced down button level |
| hr_tens | output | 4 | Hours tens digit (BCD) |
| hr_ones | output | 4 | Hours units digit (BCD) |
| min_tens | output | 4 | Minutes tens digit (BCD) |
| min_ones | output | 4 | Minutes units digit (BCD) |
| sec_tens | output | 4 | Seconds tens digit (BCD) |
| sec_ones | output | 4 | Seconds units digit (BCD) |
| edit_sel | output | 2 | Edit selection: 0 running, 1 hours, 2 minutes, 3 seconds |

## Verification
Two pairs of events can meet in one clock edge. A mode press can arrive together with an up press, and a mode press can arrive together with the one-second tick. The bench provokes the first while hours are selected. It expects the hours to move and the selection to move on to minutes, with the minutes untouched. For the second, the bench counts edges from a known prescaler restart and raises mode exactly on the tick edge. It then expects both the seconds advance and the new hours selection to show at the next sample.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef enum logic [1:0] {
    ED_RUN = 2'd0,
    ED_HR  = 2'd1,
    ED_MIN = 2'd2,
    ED_SEC = 2'd3
  } edit_t;

  localparam logic [6:0] HR_TOP = 7'd23;
  localparam logic [6:0] MS_TOP = 7'd59;

  // two BCD digits packed as {tens, ones} to a binary value
  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [6:0] b);
    logic [6:0] t;
    logic [6:0] o;
    t = b / 7'd10;
    o = b % 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  // one step up or down with wrap inside 0..top
  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [6:0] top,
                                          input logic down);
    logic [6:0] b;
    logic [6:0] n;
    b = bcd_to_bin(v);
    if (down) n = (b == 7'd0) ? top : b - 7'd1;
    else      n = (b == top) ? 7'd0 : b + 7'd1;
    return bin_to_bcd(n);
  endfunction

  function automatic logic bcd_at_top(input logic [7:0] v, input logic [6:0] top);
    return bcd_to_bin(v) == top;
  endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/tod_rise.sv
module tod_rise #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev;
    always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl[i];
    end
    assign pulse[i] = lvl[i] && !prev;
  end
endmodule

// File: rtl/tod_mode_fsm.sv
module tod_mode_fsm
  import tod_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_p,
  output edit_t state
);
  edit_t nxt;

  always_comb begin
    unique case (state)
      ED_RUN:  nxt = ED_HR;
      ED_HR:   nxt = ED_MIN;
      ED_MIN:  nxt = ED_SEC;
      default: nxt = ED_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= ED_RUN;
    else if (mode_p) state <= nxt;
  end
endmodule

// File: rtl/tod_time_regs.sv
module tod_time_regs
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  edit_t      edit,
  input  logic       up_p,
  input  logic       dn_p,
  output logic [7:0] hr,
  output logic [7:0] mn,
  output logic [7:0] sc,
  output logic       sec_wrap,
  output logic       min_wrap
);
  logic adj;
  logic adv;

  assign adj      = up_p ^ dn_p;
  assign adv      = tick && (edit == ED_RUN);
  assign sec_wrap = adv && bcd_at_top(sc, MS_TOP);
  assign min_wrap = sec_wrap && bcd_at_top(mn, MS_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr <= 8'h12;
      mn <= 8'h00;
      sc <= 8'h00;
    end else begin
      unique case (edit)
        ED_RUN: begin
          if (adv)      sc <= bcd_step(sc, MS_TOP, 1'b0);
          if (sec_wrap) mn <= bcd_step(mn, MS_TOP, 1'b0);
          if (min_wrap) hr <= bcd_step(hr, HR_TOP, 1'b0);
        end
        ED_HR:  if (adj) hr <= bcd_step(hr, HR_TOP, dn_p);
        ED_MIN: if (adj) mn <= bcd_step(mn, MS_TOP, dn_p);
        default: if (adj) sc <= bcd_step(sc, MS_TOP, dn_p);
      endcase
    end
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_mode,
  input  logic       btn_up,
  input  logic       btn_down,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] min_tens,
  output logic [3:0] min_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_ones,
  output logic [1:0] edit_sel
);
  localparam int unsigned NBTN = 3;

  logic [NBTN-1:0] btn_lvl;
  logic [NBTN-1:0] btn_pulse;
  logic            mode_p;
  logic            up_p;
  logic            dn_p;
  logic            tick_w;
  logic            run_w;
  logic            sec_wrap;
  logic            min_wrap;
  edit_t           edit_st;
  logic [7:0]      hr_q;
  logic [7:0]      mn_q;
  logic [7:0]      sc_q;

  assign btn_lvl = {btn_down, btn_up, btn_mode};
  assign mode_p  = btn_pulse[0];
  assign up_p    = btn_pulse[1];
  assign dn_p    = btn_pulse[2];
  assign run_w   = (edit_st == ED_RUN);

  tod_rise #(.N(NBTN)) u_rise (
    .clk(clk), .rst_n(rst_n), .lvl(btn_lvl), .pulse(btn_pulse)
  );

  tod_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_p(mode_p), .state(edit_st)
  );

  tod_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_w)
  );

  tod_time_regs u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .edit(edit_st),
    .up_p(up_p), .dn_p(dn_p), .hr(hr_q), .mn(mn_q), .sc(sc_q),
    .sec_wrap(sec_wrap), .min_wrap(min_wrap)
  );

  assign {hr_tens, hr_ones}   = hr_q;
  assign {min_tens, min_ones} = mn_q;
  assign {sec_tens, sec_ones} = sc_q;
  assign edit_sel             = edit_st;
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] edit_sel,
  input logic [7:0] hr,
  input logic [7:0] mn,
  input logic [7:0] sc,
  input logic       tick,
  input logic       mode_p,
  input logic       up_p,
  input logic       dn_p,
  input logic       sec_wrap,
  input logic       min_wrap
);
  // R3: each field stays inside its BCD range
  a_r3_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
    sc[3:0] <= 4'd9 && sc[7:4] <= 4'd5 && mn[3:0] <= 4'd9 && mn[7:4] <= 4'd5 &&
    ((hr[7:4] < 4'd2) ? (hr[3:0] <= 4'd9) : (hr[7:4] == 4'd2 && hr[3:0] <= 4'd3)));

  // R2: a mode press steps the selection by one, wrapping 3 to 0
  a_r2_mode_step: assert property (@(posedge clk) disable iff (!rst_n)
    mode_p |=> edit_sel == $past(edit_sel) + 2'd1);

  // R6: no tick reaches the time while a field is selected
  a_r6_no_tick_in_edit: assert property (@(posedge clk) disable iff (!rst_n)
    (edit_sel != 2'd0) |-> !tick);

  // R6, R10: the time is frozen in edit unless exactly one of up or down rose
  a_r6_frozen_in_edit: assert property (@(posedge clk) disable iff (!rst_n)
    (edit_sel != 2'd0 && !(up_p ^ dn_p)) |=> ($stable(hr) && $stable(mn) && $stable(sc)));

  // R4, R11: while running, only a tick changes the time
  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (edit_sel == 2'd0 && !tick) |=> ($stable(hr) && $stable(mn) && $stable(sc)));

  // R4: ticks are single-cycle pulses
  a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R5: a minute carry lands on xx:00:00 with the hours moved
  a_r5_hour_carry: assert property (@(posedge clk) disable iff (!rst_n)
    min_wrap |=> (mn == 8'h00 && sc == 8'h00 && hr != $past(hr)));

  // R5: a seconds wrap leaves seconds at 00
  a_r5_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> sc == 8'h00);
endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .edit_sel(edit_sel), .hr(hr_q), .mn(mn_q), .sc(sc_q),
  .tick(tick_w), .mode_p(mode_p), .up_p(up_p), .dn_p(dn_p),
  .sec_wrap(sec_wrap), .min_wrap(min_wrap)
);

// File: tb/tb_tod_clock.sv
module tb_tod_clock;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bm = 1'b0, bu = 1'b0, bd = 1'b0;
  logic [3:0] ht, ho, mt, mo, st, so;
  logic [1:0] sel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_clock #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .btn_mode(bm), .btn_up(bu), .btn_down(bd),
    .hr_tens(ht), .hr_ones(ho), .min_tens(mt), .min_ones(mo),
    .sec_tens(st), .sec_ones(so), .edit_sel(sel)
  );

  task automatic chk(input int h, input int m, input int s, input int e, input string tag);
    logic [25:0] act, exp;
    act = {ht, ho, mt, mo, st, so, sel};
    exp = {4'(h/10), 4'(h%10), 4'(m/10), 4'(m%10), 4'(s/10), 4'(s%10), 2'(e)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d%0d:%0d%0d:%0d%0d sel=%0d, expected %02d:%02d:%02d sel=%0d",
               tag, ht, ho, mt, mo, st, so, sel, h, m, s, e);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 mode, 1 up, 2 down, 3 up+down; held for 'hold' cycles
  task automatic press(input int which, input int hold);
    @(negedge clk);
    bm = (which == 0);
    bu = (which == 1) || (which == 3);
    bd = (which == 2) || (which == 3);
    waitn(hold);
    bm = 1'b0; bu = 1'b0; bd = 1'b0;
  endtask

  task automatic t_reset_and_run();
    rst_n = 1'b0;
    waitn(3);
    rst_n = 1'b1;
    chk(12, 0, 0, 0, "R1 reset state");
    waitn(DIV - 1);
    chk(12, 0, 0, 0, "R4 no advance before first tick");
    waitn(1);
    chk(12, 0, 1, 0, "R4 first advance");
    waitn(DIV);
    chk(12, 0, 2, 0, "R4 second advance");
  endtask

  task automatic t_edit_hours();
    press(0, 1);
    chk(12, 0, 2, 1, "R2 mode to hours");
    press(1, 4);
    chk(13, 0, 2, 1, "R9 held up gives one step (R7)");
    press(2, 1);
    chk(12, 0, 2, 1, "R8 down on hours");
    press(3, 1);
    chk(12, 0, 2, 1, "R10 up and down together");
    waitn(3 * DIV);
    chk(12, 0, 2, 1, "R6 frozen while editing");
    for (int i = 0; i < 13; i++) press(2, 1);
    chk(23, 0, 2, 1, "R8 hours wrap 00 to 23");
    press(1, 1);
    chk(0, 0, 2, 1, "R7 hours wrap 23 to 00 without carry");
    press(2, 2);
    press(2, 1);
    chk(22, 0, 2, 1, "R8 hours down twice");
  endtask

  task automatic t_mode_with_up();
    @(negedge clk);
    bm = 1'b1; bu = 1'b1;
    @(negedge clk);
    bm = 1'b0; bu = 1'b0;
    chk(23, 0, 2, 2, "R12 up with mode hits hours then selects minutes");
    press(2, 1);
    chk(23, 59, 2, 2, "R8 minutes wrap 00 to 59 without borrow");
    press(0, 1);
    chk(23, 59, 2, 3, "R2 mode to seconds");
    for (int i = 0; i < 3; i++) press(2, 1);
    chk(23, 59, 59, 3, "R8 seconds wrap 00 to 59");
  endtask

  task automatic t_rollover_and_tick_race();
    press(0, 1);  // applied at edge E, returns at first negedge after E
    press(1, 1);  // applied at E+2, returns at negedge after E+2
    chk(23, 59, 59, 0, "R11 up ignored while running (R2 wrap to 0)");
    waitn(7);
    chk(23, 59, 59, 0, "R6 full period after leaving edit");
    waitn(1);
    chk(0, 0, 0, 0, "R5 rollover 23:59:59 to 00:00:00");
    waitn(9);
    bm = 1'b1;     // press sampled at the tick edge E+20
    @(negedge clk);
    bm = 1'b0;
    chk(0, 0, 1, 1, "R12 tick and mode in same cycle");
    waitn(2 * DIV);
    chk(0, 0, 1, 1, "R6 no advance after entering edit");
  endtask

  initial begin
    t_reset_and_run();
    t_edit_hours();
    t_mode_with_up();
    t_rollover_and_tick_race();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule